// File: doc/BRIEF.md
# Filtered Bus Trace Buffer

This block sits beside a 32-bit AHB-style system bus and observes every completed transfer. Each transfer that is allowed through the filters becomes one 128-bit line in an on-chip circular memory. A line holds a free-running time tag, the transfer address, the data word and a small info word. The filters can drop reads or writes, drop transfers that end in a RETRY response, drop transfers from selected masters, or keep only one masked address window. A host reads and writes the eight control registers and reads the trace memory back through a simple synchronous port.

A first break pair, armed by bit 0 of its address register, acts as a watchpoint. When it is hit, the buffer goes on storing a programmed number of further lines. It then raises a debug-entry request and stops tracing. A statistics pulse follows every observed transfer. When asked, it is gated by the same filter verdict that decides trace storage.

Top module: `bus_trace_buf`

## Requirements
- R1: On a synchronous reset (rst_n low at a clock edge), the enable bit takes the inverse of brk_in and all other control fields clear. The index, the time tag and dbg_req go to zero.
- R2: A host read (host_en=1, host_we=0) returns data on host_rdata one cycle later. Control at offset 0x00 reads as: bit0 enable, bit1 delay-mode, bit2 drop-writes, bit3 drop-reads, bit4 window filter, bit5 retry filter, bits7:6 bus width (always 2'b00), bit8 statistics filter, bits22:16 delay count. Every other bit reads 0. The other offsets are 0x04 index, 0x08 time tag, 0x0C master filter, 0x10/0x14 break 1 address/mask and 0x18/0x1C break 2 address/mask.
- R3: Each stored line is written at the index, and the index then advances by one, wrapping from DEPTH-1 to 0. A host write to 0x04 loads the index.
- R4: Line n is read at 0x10000+16*n. Word 0x0 gives the time tag, 0x4 the address, 0x8 the data, and 0xC the info word {16'b0, master in bits 15:8, 5'b0, resp in bits 2:1, write in bit 0}.
- R5: With control bit2 set, writes are not stored. With bit3 set, reads are not stored.
- R6: With control bit5 set, transfers with resp 2'b10 (RETRY) are not stored. Other responses are still stored.
- R7: With control bit4 set, only transfers with ((addr ^ break2) & mask2 & 0xFFFFFFFC) == 0 are stored.
- R8: A transfer from master m is not stored when bit m of the master filter register (0x0C) is 1.
- R9: When enabled, not in delay mode, and break 1 is armed (bit0 of 0x10) and matched under mask 1 (bits 31:2), the buffer enters delay mode. Control bit1 reads 1 from then on, and the current delay count is loaded. That transfer is stored if it passes the filters. Exactly that many further lines are stored. In the next cycle with a transfer, or the next cycle at all, dbg_req rises, enable and delay mode clear, and nothing more is stored. Any host write to control clears dbg_req.
- R10: stat_pulse is high one cycle after each observed transfer. When control bit8 is set, it stays low for transfers that the filters would refuse.
- R11: The time tag increments every cycle, loads from host writes to 0x08, and its value in the storing cycle is captured into the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_in | input | 1 | Break level; sets enable's reset value |
| mon_valid | input | 1 | A bus transfer completes this cycle |
| mon_addr | input | 32 | Transfer address |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_resp | input | 2 | Response code, 2'b10 = RETRY |
| mon_master | input | MW | Master number |
| mon_data | input | 32 | Transfer data word |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1 |
| host_addr | input | 17 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the strobe |
| dbg_req | output | 1 | Debug-entry request, held until control is written |
| stat_pulse | output | 1 | Filtered statistics pulse |

## Verification
A monitored transfer is stored on the clock edge where mon_valid is seen. The index and memory contents are visible to a host read issued in the following cycle. stat_pulse is due one edge after the transfer. Register and trace reads return data one edge after the strobe. The bench drives every input at a falling edge and samples at the next falling edge, so each result is read exactly one rising edge after its cause. For the watchpoint, dbg_req is checked low right after the last allowed line and high one edge later, together with an unchanged index.

// File: rtl/bus_trace_buf.sv
module bus_trace_buf #(
  parameter int DEPTH = 64,
  parameter int NMST  = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int MW   = $clog2(NMST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_in,
  input  logic          mon_valid,
  input  logic [31:0]   mon_addr,
  input  logic          mon_write,
  input  logic [1:0]    mon_resp,
  input  logic [MW-1:0] mon_master,
  input  logic [31:0]   mon_data,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [16:0]   host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          dbg_req,
  output logic          stat_pulse
);
  localparam logic [1:0]  RESP_RETRY = 2'b10;
  localparam logic [31:0] WMASK = 32'hFFFF_FFFC;

  logic en, dm, fw, fr, af, rf, pf;
  logic [6:0] dcnt, cnt;
  logic [IDXW-1:0] idx;
  logic [31:0] tag, ba1, bm1, ba2, bm2;
  logic [NMST-1:0] mflt;
  logic [127:0] mem [DEPTH];
  logic [127:0] line;
  logic [31:0] info, rd_mux;

  wire hit1   = (((mon_addr ^ ba1) & bm1 & WMASK) == 32'd0) && ba1[0];
  wire in_win = (((mon_addr ^ ba2) & bm2 & WMASK) == 32'd0);
  wire pass   = !(fw && mon_write) && !(fr && !mon_write) &&
                !(rf && mon_resp == RESP_RETRY) && !(af && !in_win) &&
                !mflt[mon_master];
  wire expire = dm && cnt == 7'd0;
  wire store  = mon_valid && en && !expire && pass;
  wire trig   = mon_valid && en && !dm && hit1;
  wire wsel   = host_en && host_we && !host_addr[16];
  wire [IDXW-1:0] idx_nxt = (idx == IDXW'(DEPTH - 1)) ? '0 : idx + 1'b1;

  assign info = {16'd0, 8'(mon_master), 5'd0, mon_resp, mon_write};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= !brk_in;
      dm <= 1'b0; fw <= 1'b0; fr <= 1'b0; af <= 1'b0; rf <= 1'b0; pf <= 1'b0;
      dcnt <= '0; cnt <= '0; idx <= '0; tag <= '0;
      ba1 <= '0; bm1 <= '0; ba2 <= '0; bm2 <= '0; mflt <= '0;
      dbg_req <= 1'b0;
    end else begin
      tag <= tag + 32'd1;
      if (store) idx <= idx_nxt;
      if (trig) begin
        dm  <= 1'b1;
        cnt <= dcnt;
      end else if (expire) begin
        dm      <= 1'b0;
        en      <= 1'b0;
        dbg_req <= 1'b1;
      end else if (store && dm) begin
        cnt <= cnt - 7'd1;
      end
      if (wsel) begin
        case (host_addr[4:2])
          3'd0: begin
            en <= host_wdata[0];
            fw <= host_wdata[2];
            fr <= host_wdata[3];
            af <= host_wdata[4];
            rf <= host_wdata[5];
            pf <= host_wdata[8];
            dcnt <= host_wdata[22:16];
            dm <= 1'b0;
            dbg_req <= 1'b0;
          end
          3'd1: idx  <= host_wdata[IDXW-1:0];
          3'd2: tag  <= host_wdata;
          3'd3: mflt <= host_wdata[NMST-1:0];
          3'd4: ba1  <= host_wdata;
          3'd5: bm1  <= host_wdata;
          3'd6: ba2  <= host_wdata;
          default: bm2 <= host_wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[idx] <= {tag, mon_addr, mon_data, info};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_pulse <= 1'b0;
    else        stat_pulse <= mon_valid && (!pf || pass);
  end

  assign line = mem[host_addr[IDXW+3:4]];

  always_comb begin
    rd_mux = '0;
    if (host_addr[16]) begin
      case (host_addr[3:2])
        2'd0: rd_mux = line[127:96];
        2'd1: rd_mux = line[95:64];
        2'd2: rd_mux = line[63:32];
        default: rd_mux = line[31:0];
      endcase
    end else begin
      case (host_addr[4:2])
        3'd0: rd_mux = {9'd0, dcnt, 7'd0, pf, 2'b00, rf, af, fr, fw, dm, en};
        3'd1: rd_mux = 32'(idx);
        3'd2: rd_mux = tag;
        3'd3: rd_mux = 32'(mflt);
        3'd4: rd_mux = ba1;
        3'd5: rd_mux = bm1;
        3'd6: rd_mux = ba2;
        default: rd_mux = bm2;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_en && !host_we) host_rdata <= rd_mux;
  end
endmodule

module bus_trace_buf_chk #(
  parameter int DEPTH = 64,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_en,
  input logic            host_we,
  input logic [16:0]     host_addr,
  input logic [31:0]     host_rdata,
  input logic            mon_valid,
  input logic            pf,
  input logic            pass,
  input logic            store,
  input logic            trig,
  input logic            en,
  input logic            dm,
  input logic [IDXW-1:0] idx,
  input logic            dbg_req,
  input logic            stat_pulse
);
  wire ctrl_wr = host_en && host_we && !host_addr[16] && host_addr[4:2] == 3'd0;
  wire idx_wr  = host_en && host_we && !host_addr[16] && host_addr[4:2] == 3'd1;

  p_ctrl_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && host_addr == 17'd0) |=>
      (host_rdata[31:23] == 9'd0 && host_rdata[15:9] == 7'd0 && host_rdata[7:6] == 2'b00));

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !idx_wr) |=>
      (idx == (($past(idx) == IDXW'(DEPTH - 1)) ? '0 : $past(idx) + 1'b1)));

  p_req_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (!en && !dm && !store));

  p_trig_dm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ctrl_wr) |=> dm);

  p_stat_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse |-> $past(mon_valid));

  p_stat_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && pf && !pass) |=> !stat_pulse);
endmodule

bind bus_trace_buf bus_trace_buf_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
  .host_addr(host_addr), .host_rdata(host_rdata), .mon_valid(mon_valid),
  .pf(pf), .pass(pass), .store(store), .trig(trig), .en(en), .dm(dm),
  .idx(idx), .dbg_req(dbg_req), .stat_pulse(stat_pulse)
);

// File: tb/bus_trace_buf_tb.sv
module bus_trace_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0, brk_in = 1'b1;
  logic mon_valid = 1'b0, mon_write = 1'b0;
  logic [31:0] mon_addr = '0, mon_data = '0;
  logic [1:0] mon_resp = '0;
  logic [3:0] mon_master = '0;
  logic host_en = 1'b0, host_we = 1'b0;
  logic [16:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic dbg_req, stat_pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic last_stat;
  logic [31:0] rd;

  always #10 clk = ~clk;

  bus_trace_buf u_dut (
    .clk(clk), .rst_n(rst_n), .brk_in(brk_in), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_write(mon_write), .mon_resp(mon_resp),
    .mon_master(mon_master), .mon_data(mon_data), .host_en(host_en),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dbg_req(dbg_req), .stat_pulse(stat_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic rdr(input logic [16:0] a, output logic [31:0] d);
    host_en = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_en = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] r,
                      input logic [3:0] m, input logic [31:0] d);
    mon_valid = 1'b1; mon_addr = a; mon_write = w; mon_resp = r;
    mon_master = m; mon_data = d;
    @(negedge clk);
    last_stat = stat_pulse;
    mon_valid = 1'b0;
  endtask

  task automatic do_reset(input logic b);
    brk_in = b; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    brk_in = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    rdr(17'h0, rd);  check("R1 ctrl after reset brk high", rd, 32'h0);
    rdr(17'h4, rd);  check("R1 index after reset", rd, 32'h0);
    check("R1 dbg_req after reset", {31'd0, dbg_req}, 32'h0);
    do_reset(1'b0);
    rdr(17'h0, rd);  check("R1 ctrl after reset brk low", rd, 32'h1);
  endtask

  task automatic t_ctrl;
    wr(17'h0, 32'hFFFF_FFFF);
    rdr(17'h0, rd);  check("R2 ctrl layout and reserved zero", rd, 32'h007F_013D);
    wr(17'h0, 32'h1);
    rdr(17'h0, rd);  check("R2 ctrl rewrite", rd, 32'h1);
  endtask

  task automatic t_format;
    wr(17'h4, 32'd5);
    wr(17'h8, 32'd1000);
    xfer(32'h1234_5678, 1'b1, 2'b00, 4'd2, 32'hCAFE_F00D);
    xfer(32'h0000_0040, 1'b0, 2'b01, 4'd7, 32'h0BAD_BEEF);
    rdr(17'h4, rd);  check("R3 index after two lines", rd, 32'd7);
    rdr(17'h10050, rd); check("R11 tag captured", rd, 32'd1000);
    rdr(17'h10054, rd); check("R4 address word", rd, 32'h1234_5678);
    rdr(17'h10058, rd); check("R4 data word", rd, 32'hCAFE_F00D);
    rdr(17'h1005C, rd); check("R4 info word", rd, 32'h0000_0201);
    rdr(17'h10060, rd); check("R11 tag next cycle", rd, 32'd1001);
    rdr(17'h1006C, rd); check("R4 info word read", rd, 32'h0000_0702);
  endtask

  task automatic t_wrap;
    wr(17'h4, 32'd63);
    xfer(32'h100, 1'b1, 2'b00, 4'd0, 32'h1);
    rdr(17'h4, rd);  check("R3 index wraps", rd, 32'd0);
  endtask

  task automatic t_rw_filter;
    wr(17'h4, 32'd10);
    wr(17'h0, 32'h5);
    xfer(32'h200, 1'b1, 2'b00, 4'd0, 32'h0);
    check("R10 stat unfiltered", {31'd0, last_stat}, 32'h1);
    rdr(17'h4, rd);  check("R5 write dropped", rd, 32'd10);
    xfer(32'h200, 1'b0, 2'b00, 4'd0, 32'h0);
    rdr(17'h4, rd);  check("R5 read kept", rd, 32'd11);
    wr(17'h0, 32'h109);
    xfer(32'h200, 1'b0, 2'b00, 4'd0, 32'h0);
    check("R10 stat gated", {31'd0, last_stat}, 32'h0);
    rdr(17'h4, rd);  check("R5 read dropped", rd, 32'd11);
    xfer(32'h200, 1'b1, 2'b00, 4'd0, 32'h0);
    check("R10 stat passed", {31'd0, last_stat}, 32'h1);
    rdr(17'h4, rd);  check("R5 write kept", rd, 32'd12);
  endtask

  task automatic t_retry;
    wr(17'h0, 32'h21);
    xfer(32'h300, 1'b1, 2'b10, 4'd0, 32'h0);
    rdr(17'h4, rd);  check("R6 retry dropped", rd, 32'd12);
    xfer(32'h300, 1'b1, 2'b01, 4'd0, 32'h0);
    rdr(17'h4, rd);  check("R6 error kept", rd, 32'd13);
  endtask

  task automatic t_window;
    wr(17'h18, 32'h8000_0000);
    wr(17'h1C, 32'hF000_0000);
    wr(17'h0, 32'h11);
    xfer(32'h8123_0000, 1'b1, 2'b00, 4'd0, 32'h0);
    rdr(17'h4, rd);  check("R7 inside window", rd, 32'd14);
    xfer(32'h9000_0000, 1'b1, 2'b00, 4'd0, 32'h0);
    rdr(17'h4, rd);  check("R7 outside window", rd, 32'd14);
  endtask

  task automatic t_master;
    wr(17'h0, 32'h1);
    wr(17'hC, 32'h8);
    xfer(32'h400, 1'b1, 2'b00, 4'd3, 32'h0);
    rdr(17'h4, rd);  check("R8 master 3 dropped", rd, 32'd14);
    xfer(32'h400, 1'b1, 2'b00, 4'd2, 32'h0);
    rdr(17'h4, rd);  check("R8 master 2 kept", rd, 32'd15);
    wr(17'hC, 32'h0);
  endtask

  task automatic t_break;
    wr(17'h4, 32'd20);
    wr(17'h10, 32'h0000_0101);
    wr(17'h14, 32'hFFFF_FFFF);
    wr(17'h0, 32'h0002_0001);
    xfer(32'h200, 1'b1, 2'b00, 4'd0, 32'h0);
    xfer(32'h100, 1'b1, 2'b00, 4'd0, 32'h0);
    rdr(17'h0, rd);  check("R9 delay mode shown", rd, 32'h0002_0003);
    xfer(32'h204, 1'b1, 2'b00, 4'd0, 32'h0);
    xfer(32'h208, 1'b1, 2'b00, 4'd0, 32'h0);
    check("R9 no request before countdown ends", {31'd0, dbg_req}, 32'h0);
    xfer(32'h20C, 1'b1, 2'b00, 4'd0, 32'h0);
    check("R9 request raised", {31'd0, dbg_req}, 32'h1);
    rdr(17'h4, rd);  check("R9 lines stored", rd, 32'd24);
    rdr(17'h0, rd);  check("R9 enable cleared", rd, 32'h0002_0000);
    wr(17'h0, 32'h1);
    check("R9 request cleared by write", {31'd0, dbg_req}, 32'h0);
    xfer(32'h100, 1'b1, 2'b00, 4'd0, 32'h0);
    xfer(32'h200, 1'b1, 2'b00, 4'd0, 32'h0);
    check("R9 zero delay request", {31'd0, dbg_req}, 32'h1);
    rdr(17'h4, rd);  check("R9 zero delay stores only hit", rd, 32'd25);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_format();
    t_wrap();
    t_rw_filter();
    t_retry();
    t_window();
    t_master();
    t_break();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule